// File: doc/BRIEF.md
# Ethernet Frame Pad and FCS Appender

This block completes an outgoing Ethernet frame on its way to the media side. Frame data arrives as a byte stream. The beat that carries the final byte also carries two controls: `in_fcs_en` requests an appended frame check sequence, and `in_bad_fcs` forces a deliberately invalid one. The block forwards the data bytes. When `in_fcs_en` is set, it adds zero bytes to short frames so that the data reaches 60 bytes. It then appends the 4-byte CRC-32, either correct or corrupted. When padding and check bytes are being produced, input is stalled.

After the final output byte, a one-cycle status record reports several things. It gives the total number of bytes sent, with the check bytes included. It says whether the frame exceeded the programmable maximum length; such frames are flagged but never cut short. It also echoes the two controls.

Top module: `eth_frame_finisher`

## Requirements
- R1: Each accepted input byte (`in_valid` and `in_ready` both high at a clock edge) appears on `out_data` with `out_valid` high in the following cycle, in input order and unchanged.
- R2: With `in_fcs_en`=1 and `in_bad_fcs`=0, four bytes follow the frame data (and any padding). They carry the complement of a CRC-32 over all preceding bytes. The CRC uses polynomial 0x04C11DB7 in reflected form, starts from all ones, processes each byte least significant bit first, and its complement is sent least significant byte first.
- R3: With both controls 0, nothing is appended. `out_last` is high on the last data byte, and `out_valid` is low in the cycle after any byte that has `out_last` high.
- R4: With `in_bad_fcs`=1, the four appended bytes are the bitwise inverse of the correct value from R2. This holds whatever the value of `in_fcs_en`.
- R5: When `in_fcs_en`=1 and the frame has fewer than 60 data bytes, zero bytes are inserted after the data until 60 bytes have been sent, and the check bytes follow them. With `in_fcs_en`=0, no padding is added, even when `in_bad_fcs`=1.
- R6: `stat_babble` is 1 exactly when the total byte count, check bytes included, exceeds the 11-bit `cfg_max_len` (typically 1518). Such a frame is still sent in full.
- R7: `stat_valid` is high for one cycle, in the cycle right after the byte with `out_last`. The record carries `stat_len` (total bytes sent), `stat_fcs` and `stat_bad`, the last two being the controls taken from the final input beat.
- R8: After the final input beat is accepted, `in_ready` stays low for (padding bytes + appended bytes + 1) cycles, and then returns high.
- R9: While reset is asserted and just after it, `out_valid` and `stat_valid` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_max_len | input | 11 | Maximum frame length in bytes, check bytes included |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block accepts an input byte |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Final byte of the frame |
| in_fcs_en | input | 1 | Append check sequence and pad (sampled with `in_last`) |
| in_bad_fcs | input | 1 | Append inverted check sequence (sampled with `in_last`) |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the finished frame |
| stat_valid | output | 1 | Status record present, one cycle |
| stat_len | output | 16 | Total bytes sent for the frame |
| stat_babble | output | 1 | Frame longer than `cfg_max_len` |
| stat_fcs | output | 1 | Echo of the append control |
| stat_bad | output | 1 | Echo of the corrupt control |

## Verification
Frames are sent with each combination of the two controls. Frame lengths are chosen to sit on each side of the 60-byte padding threshold, which separates padded frames from unpadded ones and shows that the control, not the length alone, gates the padding. A nine-byte frame with a published CRC-32 value fixes the bit and byte order of the check bytes independently of the bench model. Maximum-length settings just below, at and above the final length separate an off-by-one in the babble comparison from one that leaves the check bytes out. Random lengths, controls and input gaps then exercise the stall behaviour and CRC continuity across idle cycles.

// File: rtl/eth_frame_finisher.sv
module eth_frame_finisher #(
  parameter int LEN_W    = 16,
  parameter int MAXL_W   = 11,
  parameter int MIN_DATA = 60,
  parameter int FCS_B    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MAXL_W-1:0] cfg_max_len,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic              in_fcs_en,
  input  logic              in_bad_fcs,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              out_last,
  output logic              stat_valid,
  output logic [LEN_W-1:0]  stat_len,
  output logic              stat_babble,
  output logic              stat_fcs,
  output logic              stat_bad
);
  localparam logic [31:0] POLY_R = 32'hEDB88320;
  localparam int IDX_W = $clog2(FCS_B);

  typedef enum logic [1:0] {S_DATA, S_PAD, S_FCS, S_STAT} st_t;

  st_t              st;
  logic [31:0]      crc;
  logic [LEN_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic             fcs_q, bad_q;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int i = 0; i < 8; i++)
      r = r[0] ? ((r >> 1) ^ POLY_R) : (r >> 1);
    return r;
  endfunction

  wire [LEN_W-1:0] cnt_nx  = cnt + 1'b1;
  wire [LEN_W-1:0] max_ext = LEN_W'(cfg_max_len);
  wire [31:0]      fcs_w   = bad_q ? crc : ~crc;
  wire [7:0]       fcs_b   = fcs_w[8*idx +: 8];
  wire             take    = in_valid && in_ready;
  wire             pad_nd  = in_fcs_en && (cnt_nx < LEN_W'(MIN_DATA));
  wire             tail    = in_fcs_en || in_bad_fcs;

  assign in_ready = (st == S_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_DATA; crc <= '1; cnt <= '0; idx <= '0;
      fcs_q <= 1'b0; bad_q <= 1'b0;
      out_valid <= 1'b0; out_data <= '0; out_last <= 1'b0;
      stat_valid <= 1'b0; stat_len <= '0; stat_babble <= 1'b0;
      stat_fcs <= 1'b0; stat_bad <= 1'b0;
    end else begin
      stat_valid <= 1'b0;
      out_valid  <= 1'b0;
      out_last   <= 1'b0;
      case (st)
        S_DATA: if (take) begin
          out_valid <= 1'b1;
          out_data  <= in_data;
          crc       <= crc_step(crc, in_data);
          cnt       <= cnt_nx;
          if (in_last) begin
            fcs_q    <= in_fcs_en;
            bad_q    <= in_bad_fcs;
            idx      <= '0;
            out_last <= !tail;
            st       <= pad_nd ? S_PAD : (tail ? S_FCS : S_STAT);
          end
        end
        S_PAD: begin
          out_valid <= 1'b1;
          out_data  <= 8'd0;
          crc       <= crc_step(crc, 8'd0);
          cnt       <= cnt_nx;
          if (cnt_nx == LEN_W'(MIN_DATA)) st <= S_FCS;
        end
        S_FCS: begin
          out_valid <= 1'b1;
          out_data  <= fcs_b;
          cnt       <= cnt_nx;
          idx       <= idx + 1'b1;
          if (idx == IDX_W'(FCS_B-1)) begin
            out_last <= 1'b1;
            st       <= S_STAT;
          end
        end
        default: begin
          stat_valid  <= 1'b1;
          stat_len    <= cnt;
          stat_babble <= cnt > max_ext;
          stat_fcs    <= fcs_q;
          stat_bad    <= bad_q;
          cnt         <= '0;
          crc         <= '1;
          st          <= S_DATA;
        end
      endcase
    end
  end

  assert_pass_through_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && in_ready) |-> (out_valid && out_data == $past(in_data)));

  assert_gap_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |=> !out_valid);

  assert_pad_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && stat_fcs) |-> (stat_len >= LEN_W'(MIN_DATA + FCS_B)));

  assert_babble_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> (stat_babble == (stat_len > max_ext)));

  assert_stat_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> $past(out_valid && out_last));

  assert_stat_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |=> !stat_valid);
endmodule

// File: tb/eth_frame_finisher_test.sv
module eth_frame_finisher_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] cfg_max_len = 11'd1518;
  logic        in_valid = 1'b0, in_last = 1'b0, in_fcs_en = 1'b0, in_bad_fcs = 1'b0;
  logic [7:0]  in_data = 8'd0;
  logic        in_ready, out_valid, out_last, stat_valid, stat_babble, stat_fcs, stat_bad;
  logic [7:0]  out_data;
  logic [15:0] stat_len;

  int checks = 0, errors = 0, cycles = 0, frames_done = 0;
  logic [7:0] exp_q[$], got_q[$];
  int last_idx, last_cnt;
  logic exp_fcs, exp_bad;

  always #4 clk = ~clk;

  eth_frame_finisher uut (
    .clk(clk), .rst_n(rst_n), .cfg_max_len(cfg_max_len),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .in_fcs_en(in_fcs_en), .in_bad_fcs(in_bad_fcs),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .stat_valid(stat_valid), .stat_len(stat_len), .stat_babble(stat_babble),
    .stat_fcs(stat_fcs), .stat_bad(stat_bad));

  function automatic logic [31:0] ref_crc(input logic [7:0] q[$]);
    logic [31:0] c = 32'hFFFFFFFF;
    foreach (q[k]) begin
      for (int b = 0; b < 8; b++) begin
        logic fb = c[0] ^ q[k][b];
        c = {1'b0, c[31:1]};
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        got_q.push_back(out_data);
        if (out_last) begin last_idx = got_q.size() - 1; last_cnt++; end
      end
      if (stat_valid) begin
        int bad_at = -1;
        check(got_q.size() == exp_q.size(), "R1", "byte count", got_q.size(), exp_q.size());
        foreach (exp_q[k]) if (k < got_q.size() && bad_at < 0 && got_q[k] !== exp_q[k]) bad_at = k;
        check(bad_at < 0, (exp_fcs || exp_bad) ? "R2/R4/R5" : "R1", "byte mismatch at",
              bad_at, -1);
        check(last_cnt == 1 && last_idx == exp_q.size() - 1, "R3", "out_last position", last_idx, exp_q.size() - 1);
        check(stat_len == exp_q.size(), "R7", "stat_len", stat_len, exp_q.size());
        check(stat_babble == (exp_q.size() > cfg_max_len), "R6", "stat_babble", stat_babble, exp_q.size() > cfg_max_len);
        check(stat_fcs == exp_fcs && stat_bad == exp_bad, "R7", "stat controls", {stat_fcs, stat_bad}, {exp_fcs, exp_bad});
        got_q.delete(); last_cnt = 0; last_idx = -1;
        frames_done++;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      summary();
    end
  end

  task automatic send_frame(input int len, input bit fcs, input bit bad, input int gap_pct, input bit fixed_data = 0,
                            input logic [7:0] fixed[$] = {});
    logic [7:0] d[$];
    int tail_exp, low_cnt, done0;
    logic [31:0] c;
    for (int k = 0; k < len; k++) d.push_back(fixed_data ? fixed[k] : 8'($urandom));
    exp_q = d;
    tail_exp = 0;
    if (fcs) while (exp_q.size() < 60) begin exp_q.push_back(8'd0); tail_exp++; end
    if (fcs || bad) begin
      c = ref_crc(exp_q);
      if (!bad) c = ~c;
      for (int k = 0; k < 4; k++) exp_q.push_back(c[8*k +: 8]);
      tail_exp += 4;
    end
    exp_fcs = fcs; exp_bad = bad;
    done0 = frames_done;
    for (int k = 0; k < len; k++) begin
      while (!in_ready) @(negedge clk);
      while (int'($urandom_range(99)) < gap_pct) begin
        in_valid = 1'b0; @(negedge clk);
      end
      in_valid = 1'b1; in_data = d[k]; in_last = (k == len - 1);
      in_fcs_en = (k == len - 1) ? fcs : 1'($urandom);
      in_bad_fcs = (k == len - 1) ? bad : 1'($urandom);
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0; in_fcs_en = 1'b0; in_bad_fcs = 1'b0;
    low_cnt = 0;
    while (!in_ready) begin low_cnt++; @(negedge clk); end
    check(low_cnt == tail_exp + 1, "R8", "in_ready low cycles", low_cnt, tail_exp + 1);
    while (frames_done == done0) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v9[$];
    void'($urandom(32'h5EED_1234));
    last_cnt = 0; last_idx = -1;
    repeat (3) @(negedge clk);
    check(!out_valid && !stat_valid && in_ready, "R9", "reset outputs", {out_valid, stat_valid, in_ready}, 3'b001);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && !stat_valid && in_ready, "R9", "after reset", {out_valid, stat_valid, in_ready}, 3'b001);

    v9 = {8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    send_frame(9, 1'b0, 1'b1, 0, 1'b1, v9);
    check(exp_q[9] == 8'hD9 && exp_q[10] == 8'hC6 && exp_q[11] == 8'h0B && exp_q[12] == 8'h34,
          "R4", "known vector model", {exp_q[9], exp_q[10], exp_q[11], exp_q[12]}, 32'hD9C60B34);
    send_frame(1, 1'b1, 1'b0, 0);
    send_frame(59, 1'b1, 1'b0, 0);
    send_frame(60, 1'b1, 1'b0, 0);
    send_frame(61, 1'b1, 1'b0, 20);
    send_frame(10, 1'b0, 1'b0, 0);
    send_frame(70, 1'b1, 1'b1, 10);
    cfg_max_len = 11'd64; send_frame(60, 1'b1, 1'b0, 0);
    cfg_max_len = 11'd63; send_frame(59, 1'b1, 1'b0, 0);
    cfg_max_len = 11'd64; send_frame(61, 1'b1, 1'b0, 0);
    cfg_max_len = 11'd99; send_frame(100, 1'b0, 1'b0, 0);
    cfg_max_len = 11'd1518;
    for (int f = 0; f < 60; f++)
      send_frame(int'($urandom_range(1, 130)), 1'($urandom), 1'($urandom), 25);
    cfg_max_len = 11'd80;
    for (int f = 0; f < 20; f++)
      send_frame(int'($urandom_range(50, 120)), 1'($urandom), 1'($urandom), 0);
    repeat (4) @(negedge clk);
    summary();
  end
endmodule